// File: doc/BRIEF.md
# Debug-Mode Bus and Request Gating

This block sits between an emulation CPU and the target board it stands in for. When the debugger has the CPU paused, it holds the four target-facing bus strobes inactive. This keeps the shared data bus free for host-to-CPU traffic. It also blocks the target's maskable interrupt, non-maskable interrupt and bus-request lines from reaching the CPU. When the CPU runs, the strobes pass straight through. Each request line then reaches the CPU only while its own enable bit is set.

A host controller changes the enable bits with single-cycle set/clear commands. A command may name one bit or all three request enables at once. A fourth stored bit, the refresh-burst enable, is kept and reported here for the paused-mode refresh sequencer, but it never gates anything. The mode is sampled into a register each clock. The stored enables survive a pause and take effect again as soon as the CPU runs. The status output reports the stored values, not the gated ones.

Top module: `dbg_bus_gate`

## Requirements
- R1: One clock after a cycle with rst_n low, status_o reads 5'b01111 (paused, refresh enable set, all three request enables set). tgt_strb_n_o and cpu_req_n_o are then all ones.
- R2: While paused (status_o[4]=0), every bit of tgt_strb_n_o is 1, whatever cpu_strb_n_i holds.
- R3: While running (status_o[4]=1), tgt_strb_n_o equals cpu_strb_n_i in the same cycle.
- R4: While paused, every bit of cpu_req_n_o is 1, even with an enable set and the target request low.
- R5: While running, cpu_req_n_o[i] equals tgt_req_n_i[i] if enable i is set, and is 1 if it is clear. Bit 0 is the maskable interrupt, bit 1 the non-maskable interrupt, bit 2 the bus request; status_o[i] holds enable i.
- R6: A cycle with cmd_valid_i=1 and cmd_all_i=0 writes cmd_set_i into the single bit selected by cmd_sel_i. The codes are 0 for maskable interrupt, 1 for non-maskable interrupt, 2 for bus request and 3 for refresh. All other stored bits are left unchanged.
- R7: A cycle with cmd_valid_i=1 and cmd_all_i=1 writes cmd_set_i into all three request enables and leaves the refresh enable unchanged.
- R8: An enable command issued while running changes cpu_req_n_o in the first cycle after the command's clock edge, without any mode change.
- R9: The refresh enable is reported in status_o[3] and has no effect on tgt_strb_n_o or cpu_req_n_o.
- R10: status_o[4] takes the value of run_i sampled at the previous clock edge. The stored enables are kept unchanged across pause and run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Requested mode: 1 run, 0 paused |
| cmd_valid_i | input | 1 | Enable command strobe |
| cmd_set_i | input | 1 | 1 sets, 0 clears the addressed bit(s) |
| cmd_all_i | input | 1 | Apply to all request enables |
| cmd_sel_i | input | 2 | Bit select: 0 int, 1 nmi, 2 busrq, 3 refresh |
| cpu_strb_n_i | input | 4 | CPU-side strobes {wr, rd, iorq, mreq}, active low |
| tgt_strb_n_o | output | 4 | Target-side strobes, active low |
| tgt_req_n_i | input | 3 | Target requests {busrq, nmi, int}, active low |
| cpu_req_n_o | output | 3 | Gated requests to the CPU, active low |
| status_o | output | 5 | {running, refresh_en, busrq_en, nmi_en, int_en} |

## Verification
The bench builds the block with its default parameters: three request lines, four strobes and a refresh enable that comes out of reset set. With these values every select code reaches a stored bit, including the refresh code at the top of the select range. Random command, mode, strobe and request traffic is mixed with directed cases. These directed cases cover enables that change while running, broadcast commands that must spare the refresh bit, and enables that are kept across a pause-run round trip.

// File: rtl/dbg_gate_pkg.sv
// Package: shared command encoding for the debug bus gate.
// Assumes the request enables occupy the low select codes, refresh the next one.
package dbg_gate_pkg;
    typedef enum logic {
        CMD_CLEAR = 1'b0,
        CMD_SET   = 1'b1
    } cmd_op_e;
endpackage

// File: rtl/dbg_gate_ctrl.sv
// Module: dbg_gate_ctrl
// Holds the mode register, the per-request enables and the refresh enable.
// Assumes single-cycle commands; a broadcast touches request enables only.
module dbg_gate_ctrl #(
    parameter int NUM_REQ     = 3,
    parameter bit REFRESH_RST = 1'b1,
    localparam int SEL_W      = $clog2(NUM_REQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               cmd_valid_i,
    input  logic               cmd_set_i,
    input  logic               cmd_all_i,
    input  logic [SEL_W-1:0]   cmd_sel_i,
    output logic               run_q_o,
    output logic               refresh_q_o,
    output logic [NUM_REQ-1:0] req_en_q_o
);
    import dbg_gate_pkg::*;

    cmd_op_e op;
    assign op = cmd_op_e'(cmd_set_i);

    // Mode register: paused out of reset, follows run_i afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q_o <= 1'b0;
        else        run_q_o <= run_i;
    end

    // One enable flop per request line, written by targeted or broadcast command.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n)
                req_en_q_o[i] <= 1'b1;
            else if (cmd_valid_i && (cmd_all_i || cmd_sel_i == SEL_W'(i)))
                req_en_q_o[i] <= (op == CMD_SET);
        end
    end

    // Refresh enable: only a targeted command at the top code writes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            refresh_q_o <= REFRESH_RST;
        else if (cmd_valid_i && !cmd_all_i && cmd_sel_i == SEL_W'(NUM_REQ))
            refresh_q_o <= (op == CMD_SET);
    end
endmodule

// File: rtl/dbg_strobe_gate.sv
// Module: dbg_strobe_gate
// Forces active-low target strobes inactive while paused, passes them when running.
// Assumes strobes are active low, so inactive is logic one.
module dbg_strobe_gate #(
    parameter int NUM_STRB = 4
) (
    input  logic                run_i,
    input  logic [NUM_STRB-1:0] cpu_strb_n_i,
    output logic [NUM_STRB-1:0] tgt_strb_n_o
);
    // Per-strobe OR with the paused condition.
    for (genvar s = 0; s < NUM_STRB; s++) begin : g_strb
        always_comb tgt_strb_n_o[s] = cpu_strb_n_i[s] | ~run_i;
    end
endmodule

// File: rtl/dbg_request_gate.sv
// Module: dbg_request_gate
// Lets each active-low target request reach the CPU only when running and enabled.
// Assumes a blocked request is shown to the CPU as logic one.
module dbg_request_gate #(
    parameter int NUM_REQ = 3
) (
    input  logic               run_i,
    input  logic [NUM_REQ-1:0] req_en_i,
    input  logic [NUM_REQ-1:0] tgt_req_n_i,
    output logic [NUM_REQ-1:0] cpu_req_n_o
);
    // Each line is gated by its own enable bit and the shared mode.
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        always_comb cpu_req_n_o[r] = (run_i && req_en_i[r]) ? tgt_req_n_i[r] : 1'b1;
    end
endmodule

// File: rtl/dbg_bus_gate.sv
// Module: dbg_bus_gate (top)
// Debug-mode gating of target strobes and CPU request lines with stored enables.
// Assumes the host issues one command per cycle; status shows stored, not gated, values.
module dbg_bus_gate #(
    parameter int NUM_REQ     = 3,
    parameter int NUM_STRB    = 4,
    parameter bit REFRESH_RST = 1'b1,
    localparam int SEL_W      = $clog2(NUM_REQ + 1),
    localparam int STAT_W     = NUM_REQ + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                cmd_valid_i,
    input  logic                cmd_set_i,
    input  logic                cmd_all_i,
    input  logic [SEL_W-1:0]    cmd_sel_i,
    input  logic [NUM_STRB-1:0] cpu_strb_n_i,
    output logic [NUM_STRB-1:0] tgt_strb_n_o,
    input  logic [NUM_REQ-1:0]  tgt_req_n_i,
    output logic [NUM_REQ-1:0]  cpu_req_n_o,
    output logic [STAT_W-1:0]   status_o
);
    logic               run_q;
    logic               refresh_q;
    logic [NUM_REQ-1:0] req_en_q;

    dbg_gate_ctrl #(.NUM_REQ(NUM_REQ), .REFRESH_RST(REFRESH_RST)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i),
        .cmd_valid_i(cmd_valid_i), .cmd_set_i(cmd_set_i),
        .cmd_all_i(cmd_all_i), .cmd_sel_i(cmd_sel_i),
        .run_q_o(run_q), .refresh_q_o(refresh_q), .req_en_q_o(req_en_q)
    );

    dbg_strobe_gate #(.NUM_STRB(NUM_STRB)) strb_i (
        .run_i(run_q), .cpu_strb_n_i(cpu_strb_n_i), .tgt_strb_n_o(tgt_strb_n_o)
    );

    dbg_request_gate #(.NUM_REQ(NUM_REQ)) req_i (
        .run_i(run_q), .req_en_i(req_en_q),
        .tgt_req_n_i(tgt_req_n_i), .cpu_req_n_o(cpu_req_n_o)
    );

    // Status packs stored state: mode, refresh, then request enables.
    always_comb status_o = {run_q, refresh_q, req_en_q};
endmodule

// File: rtl/dbg_bus_gate_chk.sv
// Module: dbg_bus_gate_chk
// Port-level properties of dbg_bus_gate; attached by bind below.
module dbg_bus_gate_chk #(
    parameter int NUM_REQ     = 3,
    parameter int NUM_STRB    = 4,
    parameter bit REFRESH_RST = 1'b1,
    localparam int SEL_W      = $clog2(NUM_REQ + 1),
    localparam int STAT_W     = NUM_REQ + 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_i,
    input logic                cmd_valid_i,
    input logic                cmd_set_i,
    input logic                cmd_all_i,
    input logic [SEL_W-1:0]    cmd_sel_i,
    input logic [NUM_STRB-1:0] cpu_strb_n_i,
    input logic [NUM_STRB-1:0] tgt_strb_n_o,
    input logic [NUM_REQ-1:0]  tgt_req_n_i,
    input logic [NUM_REQ-1:0]  cpu_req_n_o,
    input logic [STAT_W-1:0]   status_o
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (status_o == {1'b0, REFRESH_RST, {NUM_REQ{1'b1}}}));

    p_strb_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[STAT_W-1] |-> (&tgt_strb_n_o));

    p_strb_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_W-1] |-> (tgt_strb_n_o == cpu_strb_n_i));

    p_req_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[STAT_W-1] |-> (&cpu_req_n_o));

    p_req_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_W-1] |-> ((cpu_req_n_o & ~status_o[NUM_REQ-1:0]) == ~status_o[NUM_REQ-1:0]));

    p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_all_i) |=>
        (status_o[NUM_REQ-1:0] == {NUM_REQ{$past(cmd_set_i)}}) && $stable(status_o[NUM_REQ]));

    p_sel0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !cmd_all_i && cmd_sel_i == '0) |=> (status_o[0] == $past(cmd_set_i)));

    p_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_i |=> (status_o[STAT_W-1] == $past(run_i)) && $stable(status_o[STAT_W-2:0]));
endmodule

bind dbg_bus_gate dbg_bus_gate_chk #(
    .NUM_REQ(NUM_REQ), .NUM_STRB(NUM_STRB), .REFRESH_RST(REFRESH_RST)
) chk_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmd_valid_i(cmd_valid_i),
    .cmd_set_i(cmd_set_i), .cmd_all_i(cmd_all_i), .cmd_sel_i(cmd_sel_i),
    .cpu_strb_n_i(cpu_strb_n_i), .tgt_strb_n_o(tgt_strb_n_o),
    .tgt_req_n_i(tgt_req_n_i), .cpu_req_n_o(cpu_req_n_o), .status_o(status_o)
);

// File: tb/dbg_bus_gate_tb_top.sv
// Bench for dbg_bus_gate: directed corners plus seeded random traffic,
// compared against a bench-side model built from the requirements.
module dbg_bus_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic       cmd_set_i = 1'b0;
    logic       cmd_all_i = 1'b0;
    logic [1:0] cmd_sel_i = 2'd0;
    logic [3:0] cpu_strb_n_i = 4'hF;
    logic [3:0] tgt_strb_n_o;
    logic [2:0] tgt_req_n_i = 3'h7;
    logic [2:0] cpu_req_n_o;
    logic [4:0] status_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of stored state.
    logic       m_run;
    logic       m_ref;
    logic [2:0] m_en;

    always #4 clk = ~clk;   // 125 MHz

    dbg_bus_gate dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmd_valid_i(cmd_valid_i),
        .cmd_set_i(cmd_set_i), .cmd_all_i(cmd_all_i), .cmd_sel_i(cmd_sel_i),
        .cpu_strb_n_i(cpu_strb_n_i), .tgt_strb_n_o(tgt_strb_n_o),
        .tgt_req_n_i(tgt_req_n_i), .cpu_req_n_o(cpu_req_n_o), .status_o(status_o)
    );

    function automatic logic [3:0] exp_strb(logic run, logic [3:0] s);
        return run ? s : 4'hF;
    endfunction

    function automatic logic [2:0] exp_req(logic run, logic [2:0] en, logic [2:0] r);
        logic [2:0] v;
        for (int i = 0; i < 3; i++) v[i] = (run && en[i]) ? r[i] : 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Model update for the inputs present at the coming edge.
    task automatic model_edge();
        m_run = run_i;
        if (cmd_valid_i) begin
            if (cmd_all_i) m_en = {3{cmd_set_i}};
            else if (cmd_sel_i == 2'd3) m_ref = cmd_set_i;
            else m_en[cmd_sel_i] = cmd_set_i;
        end
    endtask

    // Advance one clock and land at the following falling edge.
    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic check_all(input string tag);
        check(status_o == {m_run, m_ref, m_en}, {tag, " status R10"}, status_o, {m_run, m_ref, m_en});
        check(tgt_strb_n_o == exp_strb(m_run, cpu_strb_n_i), {tag, " strobes R2 R3"},
              tgt_strb_n_o, exp_strb(m_run, cpu_strb_n_i));
        check(cpu_req_n_o == exp_req(m_run, m_en, tgt_req_n_i), {tag, " requests R4 R5 R9"},
              cpu_req_n_o, exp_req(m_run, m_en, tgt_req_n_i));
    endtask

    task automatic cmd(input logic set, input logic all, input logic [1:0] sel);
        cmd_valid_i = 1'b1; cmd_set_i = set; cmd_all_i = all; cmd_sel_i = sel;
    endtask

    // Watchdog: a hung run is counted as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_run = 1'b0; m_ref = 1'b1; m_en = 3'b111;
        // R1: reset state.
        check(status_o == 5'b01111, "R1 status", status_o, 5'b01111);
        check(tgt_strb_n_o == 4'hF, "R1 strobes", tgt_strb_n_o, 4'hF);
        check(cpu_req_n_o == 3'h7, "R1 requests", cpu_req_n_o, 3'h7);

        // R2 R4: paused with everything asserted on the inputs.
        cpu_strb_n_i = 4'h0; tgt_req_n_i = 3'h0;
        #1;
        check(tgt_strb_n_o == 4'hF, "R2 paused strobes", tgt_strb_n_o, 4'hF);
        check(cpu_req_n_o == 3'h7, "R4 paused requests", cpu_req_n_o, 3'h7);

        // R3 R5: enter run, pass-through.
        run_i = 1'b1; step();
        check(tgt_strb_n_o == 4'h0, "R3 pass strobes", tgt_strb_n_o, 4'h0);
        check(cpu_req_n_o == 3'h0, "R5 pass requests", cpu_req_n_o, 3'h0);
        cpu_strb_n_i = 4'hA; #1;
        check(tgt_strb_n_o == 4'hA, "R3 pass pattern", tgt_strb_n_o, 4'hA);

        // R6 R8: disable nmi while running; effect right after the edge.
        cmd(1'b0, 1'b0, 2'd1); step();
        check(cpu_req_n_o == 3'b010, "R8 nmi blocked at once", cpu_req_n_o, 3'b010);
        check(status_o == 5'b11101, "R6 only nmi cleared", status_o, 5'b11101);

        // R9: refresh toggled, gating unchanged.
        cmd(1'b0, 1'b0, 2'd3); step();
        check(status_o == 5'b10101, "R9 refresh cleared", status_o, 5'b10101);
        check(cpu_req_n_o == 3'b010, "R9 requests unchanged", cpu_req_n_o, 3'b010);
        check(tgt_strb_n_o == 4'hA, "R9 strobes unchanged", tgt_strb_n_o, 4'hA);

        // R7: broadcast clear spares refresh, broadcast set restores.
        cmd(1'b1, 1'b0, 2'd3); step();
        cmd(1'b0, 1'b1, 2'd3); step();
        check(status_o == 5'b11000, "R7 broadcast clear", status_o, 5'b11000);
        check(cpu_req_n_o == 3'h7, "R7 all blocked", cpu_req_n_o, 3'h7);
        cmd(1'b1, 1'b1, 2'd0); step();
        check(status_o == 5'b11111, "R7 broadcast set", status_o, 5'b11111);

        // R10: enables kept across pause and reapplied in run.
        cmd(1'b0, 1'b0, 2'd2); step();
        run_i = 1'b0; step();
        check(status_o == 5'b01011, "R10 paused keeps enables", status_o, 5'b01011);
        check(cpu_req_n_o == 3'h7, "R4 paused with enables", cpu_req_n_o, 3'h7);
        run_i = 1'b1; step();
        check(cpu_req_n_o == 3'b100, "R10 enables reapplied", cpu_req_n_o, 3'b100);

        // Random traffic.
        for (int k = 0; k < 400; k++) begin
            run_i        = ($urandom % 4) != 0;
            cpu_strb_n_i = 4'($urandom);
            tgt_req_n_i  = 3'($urandom);
            if (($urandom % 3) == 0)
                cmd(1'($urandom), ($urandom % 5) == 0, 2'($urandom));
            step();
            check_all("random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule